// File: doc/BRIEF.md
# Second-Order Recursive Filter Section

This block is one second-order recursive (IIR) filter stage for a stream of signed fixed-point samples. Each sample arrives with a qualifying strobe. On every strobed cycle the stage forms a weighted sum of five terms: the new sample, the two samples before it, and the two outputs before it. It then brings that sum back to sample scale, rounds it and clamps it, and registers the result as the next output. The output is ready one clock after the strobe.

The five weights are static inputs that an external register bank drives. Each is a 16-bit signed fraction. A parameter chooses how many of its most significant bits the arithmetic actually uses, so a narrow build trades precision for smaller multipliers. A second parameter sets the sample width. The block runs on one clock and has a synchronous, active-high reset.

Top module: `bq_filter`

## Requirements
- R1: On each accepted sample the new output equals ff0·x[n] + ff1·x[n-1] + ff2·x[n-2] + fb1·y[n-1] + fb2·y[n-2], where x[n] is the current input and y[n] is an output. Both feedback products are added, not subtracted.
- R2: Each coefficient input is 16-bit two's complement with 1 sign bit and 15 fraction bits (0x4000 = 0.5, 0x8000 = -1.0). The arithmetic uses only bits [15:16-COEF_W] of each coefficient, read as a signed COEF_W-bit fraction. The lower bits have no effect.
- R3: Every product is kept at full precision. The five products are summed without wrap-around, including when every tap and every coefficient sits at its most negative value.
- R4: The sum is brought back to sample scale by adding 2^(COEF_W-2) and then shifting right arithmetically by COEF_W-1 bits. This rounds half up (a value of -0.5 LSB becomes 0; +0.5 LSB becomes +1).
- R5: A rescaled value above 2^(SAMPLE_W-1)-1 gives exactly that maximum. A value below -2^(SAMPLE_W-1) gives exactly that minimum. Out-of-range values never wrap.
- R6: On a cycle with smp_vld high, x[n-1] moves to x[n-2], the input moves to x[n-1], the previous output moves to y[n-2], and the new result appears on flt_out after that same clock edge.
- R7: While smp_vld is low, flt_out and all delay-line contents hold, whatever value smp_in carries.
- R8: A synchronous reset (rst high at a clock edge) clears both input taps, both output taps and flt_out to zero.
- R9: smp_in and flt_out are SAMPLE_W-bit signed fractions in the same format as the coefficients. Both the most negative and the most positive sample codes are handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample strobe; state advances only when high |
| smp_in | input | SAMPLE_W | Signed input sample |
| ff0_coef | input | 16 | Weight on the current input |
| ff1_coef | input | 16 | Weight on the input one sample back |
| ff2_coef | input | 16 | Weight on the input two samples back |
| fb1_coef | input | 16 | Weight on the output one sample back |
| fb2_coef | input | 16 | Weight on the output two samples back |
| flt_out | output | SAMPLE_W | Registered filter output |

## Verification
The only result is flt_out, and it is due at the clock edge that accepts a strobed sample. Every check therefore drives smp_in and smp_vld at the falling edge and reads flt_out shortly after the next rising edge. That moment is compared with a model that advances its state only when the strobe was high. On cycles with the strobe low, the same read confirms that flt_out has not moved. Reset is checked one edge after rst is raised.

// File: rtl/bq_pkg.sv
package bq_pkg;

    // Width of every coefficient input as delivered by the register bank
    localparam int COEF_IN_W = 16;

    // Number of weighted terms in the sum
    localparam int NTAP = 5;

    // Tap positions; the datapath pairs tap i with coefficient i
    typedef enum logic [2:0] {
        TAP_X0 = 3'd0,
        TAP_X1 = 3'd1,
        TAP_X2 = 3'd2,
        TAP_Y1 = 3'd3,
        TAP_Y2 = 3'd4
    } tap_e;

    // Full-width coefficient set as presented at the ports
    typedef struct packed {
        logic [COEF_IN_W-1:0] ff0;
        logic [COEF_IN_W-1:0] ff1;
        logic [COEF_IN_W-1:0] ff2;
        logic [COEF_IN_W-1:0] fb1;
        logic [COEF_IN_W-1:0] fb2;
    } coef_bank_t;

    // Product width for a sample of width sw and a coefficient of width cw
    function automatic int prod_width(input int sw, input int cw);
        return sw + cw;
    endfunction

    // Accumulator width: five terms need three guard bits
    function automatic int acc_width(input int sw, input int cw);
        return prod_width(sw, cw) + 3;
    endfunction

endpackage

// File: rtl/bq_coef_trim.sv
module bq_coef_trim
    import bq_pkg::*;
#(
    parameter int COEF_W = 8
) (
    input  coef_bank_t                    bank,
    output logic [NTAP-1:0][COEF_W-1:0]   coef
);

    logic [NTAP-1:0][COEF_IN_W-1:0] full;

    always_comb begin
        full[TAP_X0] = bank.ff0;
        full[TAP_X1] = bank.ff1;
        full[TAP_X2] = bank.ff2;
        full[TAP_Y1] = bank.fb1;
        full[TAP_Y2] = bank.fb2;
    end

    // Keep the most significant COEF_W bits of each weight
    for (genvar i = 0; i < NTAP; i++) begin : g_trim
        assign coef[i] = full[i][COEF_IN_W-1 -: COEF_W];
    end

endmodule

// File: rtl/bq_mac.sv
module bq_mac
    import bq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    localparam int PW      = prod_width(SAMPLE_W, COEF_W),
    localparam int AW      = acc_width(SAMPLE_W, COEF_W)
) (
    input  logic [NTAP-1:0][SAMPLE_W-1:0] taps,
    input  logic [NTAP-1:0][COEF_W-1:0]   coef,
    output logic signed [AW-1:0]          acc
);

    logic signed [PW-1:0] prod [NTAP];

    // Full-precision signed products
    for (genvar i = 0; i < NTAP; i++) begin : g_prod
        assign prod[i] = $signed(taps[i]) * $signed(coef[i]);
    end

    // Sign-extended sum of all terms
    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            acc = acc + {{(AW-PW){prod[i][PW-1]}}, prod[i]};
        end
    end

endmodule

// File: rtl/bq_fmt.sv
module bq_fmt
    import bq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    localparam int AW      = acc_width(SAMPLE_W, COEF_W)
) (
    input  logic signed [AW-1:0]  acc,
    output logic [SAMPLE_W-1:0]   res
);

    localparam logic signed [AW-1:0] HALF  = AW'(1) <<< (COEF_W - 2);
    localparam logic signed [AW-1:0] MAX_V = {{(AW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [AW-1:0] MIN_V = {{(AW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] scaled;

    always_comb begin
        rnd    = acc + HALF;
        scaled = rnd >>> (COEF_W - 1);
        if (scaled > MAX_V) begin
            res = MAX_V[SAMPLE_W-1:0];
        end else if (scaled < MIN_V) begin
            res = MIN_V[SAMPLE_W-1:0];
        end else begin
            res = scaled[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/bq_filter.sv
module bq_filter
    import bq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,   // 2..16
    localparam int AW      = acc_width(SAMPLE_W, COEF_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic [15:0]         ff0_coef,
    input  logic [15:0]         ff1_coef,
    input  logic [15:0]         ff2_coef,
    input  logic [15:0]         fb1_coef,
    input  logic [15:0]         fb2_coef,
    output logic [SAMPLE_W-1:0] flt_out
);

    coef_bank_t                    bank;
    logic [NTAP-1:0][COEF_W-1:0]   coef;
    logic [NTAP-1:0][SAMPLE_W-1:0] taps;
    logic signed [AW-1:0]          acc;
    logic [SAMPLE_W-1:0]           res;

    logic [SAMPLE_W-1:0] x_d1, x_d2, y_d1, y_d2;

    always_comb begin
        bank.ff0 = ff0_coef;
        bank.ff1 = ff1_coef;
        bank.ff2 = ff2_coef;
        bank.fb1 = fb1_coef;
        bank.fb2 = fb2_coef;
    end

    always_comb begin
        taps[TAP_X0] = smp_in;
        taps[TAP_X1] = x_d1;
        taps[TAP_X2] = x_d2;
        taps[TAP_Y1] = y_d1;
        taps[TAP_Y2] = y_d2;
    end

    bq_coef_trim #(.COEF_W(COEF_W)) u_trim (
        .bank (bank),
        .coef (coef)
    );

    bq_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mac (
        .taps (taps),
        .coef (coef),
        .acc  (acc)
    );

    bq_fmt #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_fmt (
        .acc  (acc),
        .res  (res)
    );

    // Delay lines advance only on strobed cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1 <= '0;
            x_d2 <= '0;
            y_d1 <= '0;
            y_d2 <= '0;
        end else if (smp_vld) begin
            x_d2 <= x_d1;
            x_d1 <= smp_in;
            y_d2 <= y_d1;
            y_d1 <= res;
        end
    end

    assign flt_out = y_d1;

endmodule

// File: rtl/bq_filter_chk.sv
module bq_filter_chk #(
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          vld,
    input logic [SW-1:0] x_in,
    input logic [SW-1:0] x_d1,
    input logic [SW-1:0] x_d2,
    input logic [SW-1:0] y_d2,
    input logic [SW-1:0] y_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (y_out == '0 && y_d2 == '0 && x_d1 == '0 && x_d2 == '0)); // R8

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst) !vld |=> $stable(y_out)); // R7

    AST_HOLD_TAPS: assert property (@(posedge clk) disable iff (rst) !vld |=> ($stable(x_d1) && $stable(x_d2) && $stable(y_d2))); // R7

    AST_X_CAPTURE: assert property (@(posedge clk) disable iff (rst) vld |=> (x_d1 == $past(x_in))); // R6

    AST_X_SHIFT: assert property (@(posedge clk) disable iff (rst) vld |=> (x_d2 == $past(x_d1))); // R6

    AST_Y_SHIFT: assert property (@(posedge clk) disable iff (rst) vld |=> (y_d2 == $past(y_out))); // R6

endmodule

bind bq_filter bq_filter_chk #(.SW(SAMPLE_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .vld   (smp_vld),
    .x_in  (smp_in),
    .x_d1  (x_d1),
    .x_d2  (x_d2),
    .y_d2  (y_d2),
    .y_out (flt_out)
);

// File: tb/bq_filter_bench.sv
module bq_filter_bench;

    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [SW-1:0] smp_in = '0;
    logic [15:0] c_ff0 = '0, c_ff1 = '0, c_ff2 = '0, c_fb1 = '0, c_fb2 = '0;
    logic [SW-1:0] y_a, y_b;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    longint mx1 [2], mx2 [2], my1 [2], my2 [2];
    int cwv [2] = '{8, 16};

    always #5 clk = ~clk;

    bq_filter #(.SAMPLE_W(SW), .COEF_W(8)) u_bq_filter (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
        .ff0_coef(c_ff0), .ff1_coef(c_ff1), .ff2_coef(c_ff2),
        .fb1_coef(c_fb1), .fb2_coef(c_fb2), .flt_out(y_a)
    );

    bq_filter #(.SAMPLE_W(SW), .COEF_W(16)) u_bq_filter_w16 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
        .ff0_coef(c_ff0), .ff1_coef(c_ff1), .ff2_coef(c_ff2),
        .fb1_coef(c_fb1), .fb2_coef(c_fb2), .flt_out(y_b)
    );

    function automatic longint trim(input logic [15:0] c, input int cw);
        longint v = longint'($signed(c));
        return v >>> (16 - cw);
    endfunction

    function automatic longint model_next(input int k, input longint xv);
        longint cw = cwv[k];
        longint acc, s;
        acc = trim(c_ff0, cwv[k]) * xv + trim(c_ff1, cwv[k]) * mx1[k]
            + trim(c_ff2, cwv[k]) * mx2[k] + trim(c_fb1, cwv[k]) * my1[k]
            + trim(c_fb2, cwv[k]) * my2[k];
        s = (acc + (longint'(1) << (cw - 2))) >>> (cw - 1);
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        return s;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp_v, input int k);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s cw=%0d actual=%0d expected=%0d", tag, cwv[k], act, exp_v);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, longint'($signed(y_a)), my1[0], 0);
        check(tag, longint'($signed(y_b)), my1[1], 1);
    endtask

    task automatic step(input logic [SW-1:0] xv, input logic v, input string tag);
        longint nx [2];
        @(negedge clk);
        smp_in  = xv;
        smp_vld = v;
        @(posedge clk);
        #1;
        if (v) begin
            for (int k = 0; k < 2; k++) begin
                nx[k]  = model_next(k, longint'($signed(xv)));
                mx2[k] = mx1[k];
                mx1[k] = longint'($signed(xv));
                my2[k] = my1[k];
                my1[k] = nx[k];
            end
        end
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
        end
        compare("R8");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_coef(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                            input logic [15:0] d, input logic [15:0] e);
        @(negedge clk);
        c_ff0 = a; c_ff1 = b; c_ff2 = c; c_fb1 = d; c_fb2 = e;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
        end
        repeat (3) @(posedge clk);
        do_reset();  // R8 reset state

        // R1 R6: impulse response with added feedback
        set_coef(16'h4000, 16'h2000, 16'h1000, 16'h4000, 16'hE000);
        step(8'd64, 1'b1, "R1");
        for (int i = 0; i < 14; i++) step(8'd0, 1'b1, "R6");

        // R7: strobe low, input wiggles, nothing moves
        step(8'd100, 1'b1, "R1");
        for (int i = 0; i < 20; i++) step(SW'($urandom), 1'b0, "R7");
        step(8'd0, 1'b1, "R6");

        // R5: positive step drives saturation high, then low
        do_reset();
        set_coef(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h4000, 16'h0000);
        for (int i = 0; i < 10; i++) step(8'd100, 1'b1, "R5");
        for (int i = 0; i < 10; i++) step(8'h80, 1'b1, "R5");

        // R3: every tap and weight at its most negative value
        do_reset();
        set_coef(16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        for (int i = 0; i < 8; i++) step(8'h80, 1'b1, "R3");

        // R4 R9: half-scale weight, all input codes, rounding and extremes
        do_reset();
        set_coef(16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        for (int i = 0; i < 256; i++) step(SW'(i), 1'b1, (i == 127 || i == 128) ? "R9" : "R4");
        set_coef(16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        for (int i = 0; i < 256; i++) step(SW'(i), 1'b1, "R4");

        // R2: low coefficient bits differ between the two widths
        do_reset();
        set_coef(16'h40FF, 16'h10FF, 16'hF0FF, 16'h20FF, 16'hE0FF);
        for (int i = 0; i < 256; i++) step(SW'(i * 37), 1'b1, "R2");

        // R1 R3 R7: random weights and samples with sporadic strobe gaps
        for (int s = 0; s < 12; s++) begin
            do_reset();
            set_coef(16'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom) >>> 1, 16'($urandom) >>> 2);
            for (int i = 0; i < 300; i++) begin
                step(SW'($urandom), ($urandom % 4) != 0, "R1");
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule